// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer Counter

This block is a general-purpose timer. It divides the system clock by a programmable amount and uses each divided step to move a counter. The counter's period is set by a programmable reload limit. The counter can count up, count down, or count up and then down in a center-aligned pattern. At the end of a count (an overflow when counting up, an underflow when counting down) it raises an update event. The event gives a one-cycle trigger pulse that other on-chip logic can use to start work. When the timer interrupt is enabled, the event also sets a sticky interrupt flag.

Software-side logic sets the timer through simple write strobes for the divider value, the reload limit, the counting mode and the interrupt enable. New divider and limit values wait in a holding register and take over only at the end of the current period, so a running period is never shortened. The mode is taken over only while the timer is stopped. Deasserting the enable stops the timer at once and returns it to zero. Counting starts again from zero when the enable returns.

Top module: `mode_timer`

## Requirements
- R1: After reset the count is 0 and irq and trig are 0. The held divider, limit, mode and interrupt enable are all 0, which means up mode, no division, limit 0 and interrupt off.
- R2: A divider value N makes the counter step once every N+1 clock cycles with en high. The first step lands on the (N+1)th rising edge after en goes high.
- R3: In up mode (mode code 0) the counter steps 0, 1, …, LIMIT. A step from LIMIT returns it to 0 and is an overflow event. A limit of 36 gives one event every 37 steps, and a limit of 0 gives an event on every step.
- R4: In down mode (mode code 1) the counter decrements. A step from 0 loads LIMIT and is an underflow event, so a run that starts at 0 underflows on its first step.
- R5: In center mode (mode code 2) the counter rises from 0. The step from LIMIT-1 to LIMIT is an overflow event. It then falls, and the step from 1 to 0 is an underflow event. With a limit of 0 the count holds at 0 and no event occurs.
- R6: trig is high for exactly the one cycle after each event. That is the same edge at which count takes its value after the event.
- R7: An event sets irq only when the interrupt enable is 1. trig pulses whatever the interrupt enable is.
- R8: irq stays set until irq_clr is high at a clock edge. If an event that sets irq arrives on the same edge as irq_clr, irq stays set.
- R9: When en is low at a clock edge, the count, the divider phase and the direction all return to 0 (direction returns to up). Counting resumes from 0 when en returns.
- R10: A divider or limit write goes into a holding register one edge after its strobe. It becomes active only at the end of a period (overflow in up mode, underflow in down and center modes) or on any edge with en low. A period that has already started runs to its old limit.
- R11: A mode write is applied only on edges with en low, so a mode write while the timer runs has no effect on counting. Mode code 3 behaves as up mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears the count and divider phase |
| psc_wr | input | 1 | Divider value write strobe |
| psc_wdata | input | PSC_W | Divider value (steps every value+1 cycles) |
| arr_wr | input | 1 | Reload limit write strobe |
| arr_wdata | input | CNT_W | Reload limit |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode code: 0 up, 1 down, 2 center, 3 up |
| ie_wr | input | 1 | Interrupt enable write strobe |
| ie_wdata | input | 1 | Interrupt enable value |
| irq_clr | input | 1 | Clears the interrupt flag |
| count | output | CNT_W | Current counter value |
| irq | output | 1 | Sticky interrupt flag |
| trig | output | 1 | One-cycle pulse per update event |

## Verification
Every result is registered once. With a divider of N, count moves on the (N+1)th enabled rising edge, and trig and irq change on that same edge as the event that causes them. A write or a clear is seen on the edge where its strobe is high, and a newly held value can act from the following edge. The bench drives every input and samples every output at the falling edge. It moves through whole clock periods only, so each expected count and event total is worked out from the number of enabled edges. trig is counted on every falling edge, which catches each one-cycle pulse exactly once.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2,
        MODE_RSVD   = 2'd3
    } tmode_e;

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr,
    input  logic [PSC_W-1:0] wdata,
    input  logic             period_end,
    output logic             tick
);

    typedef struct packed {
        logic [PSC_W-1:0] div;
        logic [PSC_W-1:0] lim_pend;
        logic [PSC_W-1:0] lim_act;
    } psc_st_t;

    psc_st_t st_d, st_q;

    assign tick = en && (st_q.div == st_q.lim_act);

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.lim_pend = wdata;
        end
        if (!en) begin
            st_d.div     = '0;
            st_d.lim_act = st_q.lim_pend;
        end else if (tick) begin
            st_d.div = '0;
            if (period_end) begin
                st_d.lim_act = st_q.lim_pend;
            end
        end else begin
            st_d.div = st_q.div + PSC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the divider phase never passes the active limit
    p_div_bound_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.div <= st_q.lim_act);

    // R9: a stopped timer restarts its divider phase
    p_div_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> st_q.div == '0);

endmodule

// File: rtl/mt_counter.sv
module mt_counter
    import mode_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    output logic [CNT_W-1:0] count,
    output logic             evt,
    output logic             period_end
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_down;
        logic [CNT_W-1:0] arr_pend;
        logic [CNT_W-1:0] arr_act;
        tmode_e           mode_pend;
        tmode_e           mode_act;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    ovf, udf;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        udf  = 1'b0;
        if (arr_wr) begin
            st_d.arr_pend = arr_wdata;
        end
        if (mode_wr) begin
            st_d.mode_pend = tmode_e'(mode_wdata);
        end
        if (!en) begin
            st_d.cnt      = '0;
            st_d.dir_down = 1'b0;
            st_d.arr_act  = st_q.arr_pend;
            st_d.mode_act = st_q.mode_pend;
        end else if (tick) begin
            case (st_q.mode_act)
                MODE_DOWN: begin
                    if (st_q.cnt == '0) begin
                        st_d.cnt     = st_q.arr_pend;
                        st_d.arr_act = st_q.arr_pend;
                        udf          = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                MODE_CENTER: begin
                    if (st_q.arr_act == '0) begin
                        st_d.cnt = '0;
                    end else if (!st_q.dir_down) begin
                        if (st_q.cnt == st_q.arr_act - ONE) begin
                            st_d.cnt      = st_q.arr_act;
                            st_d.dir_down = 1'b1;
                            ovf           = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else begin
                        if (st_q.cnt == ONE) begin
                            st_d.cnt      = '0;
                            st_d.dir_down = 1'b0;
                            st_d.arr_act  = st_q.arr_pend;
                            udf           = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                end
                default: begin
                    if (st_q.cnt == st_q.arr_act) begin
                        st_d.cnt     = '0;
                        st_d.arr_act = st_q.arr_pend;
                        ovf          = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
            endcase
        end
        evt        = ovf | udf;
        period_end = udf | (ovf & (st_q.mode_act != MODE_CENTER));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R9: stopping clears the count and direction on the next edge
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q.cnt == '0) && !st_q.dir_down);

    // R10: the count never passes the active limit
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.arr_act);

    // R10: the active limit holds for the whole running period
    p_arr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (en && !period_end) |=> $stable(st_q.arr_act));

    // R11: the mode cannot change while running
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(st_q.mode_act));

endmodule

// File: rtl/mt_irq.sv
module mt_irq (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic ie_wr,
    input  logic ie_wdata,
    input  logic clr,
    output logic irq,
    output logic trig
);

    typedef struct packed {
        logic ie;
        logic irq;
        logic trig;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trig = evt;
        if (ie_wr) begin
            st_d.ie = ie_wdata;
        end
        if (evt && st_q.ie) begin
            st_d.irq = 1'b1;
        end else if (clr) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq  = st_q.irq;
    assign trig = st_q.trig;

    // R7: with the interrupt off a clear flag stays clear
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (!st_q.irq && !st_q.ie) |=> !st_q.irq);

    // R8: a clear with no event drops the flag
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !st_q.irq);

    // R8: an enabled event wins over a clear
    p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (evt && st_q.ie) |=> st_q.irq);

endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import mode_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_wdata,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic             ie_wr,
    input  logic             ie_wdata,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             trig
);

    logic tick;
    logic evt;
    logic period_end;

    mt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .wr         (psc_wr),
        .wdata      (psc_wdata),
        .period_end (period_end),
        .tick       (tick)
    );

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tick       (tick),
        .arr_wr     (arr_wr),
        .arr_wdata  (arr_wdata),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .count      (count),
        .evt        (evt),
        .period_end (period_end)
    );

    mt_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .ie_wr    (ie_wr),
        .ie_wdata (ie_wdata),
        .clr      (irq_clr),
        .irq      (irq),
        .trig     (trig)
    );

    // R6: an event needs a divided step behind it
    p_evt_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        evt |-> tick);

endmodule

// File: tb/mode_timer_tb.sv
`timescale 1ns/1ps
module mode_timer_tb;

    logic        clk = 1'b0;
    logic        rst, en, psc_wr, arr_wr, mode_wr, ie_wr, ie_wdata, irq_clr;
    logic [15:0] psc_wdata, arr_wdata;
    logic [1:0]  mode_wdata;
    logic [15:0] count;
    logic        irq, trig;

    int n_chk = 0;
    int n_bad = 0;
    int ev_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mode_timer u_dut (
        .clk(clk), .rst(rst), .en(en),
        .psc_wr(psc_wr), .psc_wdata(psc_wdata),
        .arr_wr(arr_wr), .arr_wdata(arr_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .ie_wr(ie_wr), .ie_wdata(ie_wdata),
        .irq_clr(irq_clr),
        .count(count), .irq(irq), .trig(trig)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] psc;
        logic [15:0] arr;
        logic        ie;
        logic [15:0] cyc;
        logic [15:0] cnt;
        logic [7:0]  ev;
        logic        irq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd0, 16'd4,  1'b1, 16'd12, 16'd2, 8'd2, 1'b1},
        '{2'd0, 16'd2, 16'd3,  1'b0, 16'd20, 16'd2, 8'd1, 1'b0},
        '{2'd1, 16'd0, 16'd5,  1'b1, 16'd9,  16'd3, 8'd2, 1'b1},
        '{2'd1, 16'd1, 16'd2,  1'b0, 16'd13, 16'd0, 8'd2, 1'b0},
        '{2'd2, 16'd0, 16'd3,  1'b1, 16'd10, 16'd2, 8'd3, 1'b1},
        '{2'd2, 16'd1, 16'd4,  1'b0, 16'd17, 16'd0, 8'd2, 1'b0},
        '{2'd0, 16'd0, 16'd36, 1'b1, 16'd74, 16'd0, 8'd2, 1'b1},
        '{2'd2, 16'd0, 16'd1,  1'b1, 16'd5,  16'd1, 8'd5, 1'b1},
        '{2'd0, 16'd0, 16'd0,  1'b0, 16'd4,  16'd0, 8'd4, 1'b0},
        '{2'd2, 16'd0, 16'd0,  1'b1, 16'd6,  16'd0, 8'd0, 1'b0},
        '{2'd3, 16'd0, 16'd4,  1'b0, 16'd7,  16'd2, 8'd1, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic configure(input logic [1:0] m, input logic [15:0] p,
                             input logic [15:0] a, input logic i);
        @(negedge clk);
        en = 1'b0;
        psc_wr = 1'b1;  psc_wdata = p;
        arr_wr = 1'b1;  arr_wdata = a;
        mode_wr = 1'b1; mode_wdata = m;
        ie_wr = 1'b1;   ie_wdata = i;
        irq_clr = 1'b1;
        @(negedge clk);
        psc_wr = 1'b0; arr_wr = 1'b0; mode_wr = 1'b0; ie_wr = 1'b0; irq_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ev_cnt = 0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (trig) ev_cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        string tag;
        rst = 1'b1; en = 1'b0;
        psc_wr = 1'b0; arr_wr = 1'b0; mode_wr = 1'b0; ie_wr = 1'b0;
        psc_wdata = '0; arr_wdata = '0; mode_wdata = '0; ie_wdata = 1'b0; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run(1);
        chk("R1 count after reset", count, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 trig after reset", trig, 0);
        // R1 defaults: up, no division, limit 0, interrupt off
        ev_cnt = 0;
        en = 1'b1;
        run(2);
        chk("R1 default count", count, 0);
        chk("R1 default events", ev_cnt, 2);
        chk("R1 default irq off", irq, 0);

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            configure(VECS[v].mode, VECS[v].psc, VECS[v].arr, VECS[v].ie);
            en = 1'b1;
            run(int'(VECS[v].cyc));
            case (VECS[v].mode)
                2'd1:    tag = "R2 R4 down count";
                2'd2:    tag = "R2 R5 center count";
                2'd3:    tag = "R11 code3 as up count";
                default: tag = "R2 R3 up count";
            endcase
            chk(tag, count, int'(VECS[v].cnt));
            chk("R6 trig pulses", ev_cnt, int'(VECS[v].ev));
            chk("R7 irq", irq, int'(VECS[v].irq));
        end

        // R8: clear without event, then clear against an event
        configure(2'd0, 16'd0, 16'd2, 1'b1);
        en = 1'b1;
        run(3);
        chk("R8 irq set", irq, 1);
        irq_clr = 1'b1;
        run(1);
        irq_clr = 1'b0;
        chk("R8 irq cleared", irq, 0);
        run(1);
        irq_clr = 1'b1;
        run(1);
        irq_clr = 1'b0;
        chk("R8 event wins over clear", irq, 1);

        // R10: limit write mid-period waits for the period end
        configure(2'd0, 16'd0, 16'd9, 1'b0);
        en = 1'b1;
        run(3);
        arr_wr = 1'b1; arr_wdata = 16'd2;
        run(1);
        arr_wr = 1'b0;
        run(5);
        chk("R10 old limit kept", count, 9);
        run(4);
        chk("R10 new limit period", count, 0);
        chk("R10 events", ev_cnt, 2);
        en = 1'b0;
        run(1);
        chk("R9 disable clears count", count, 0);

        // R9: divider phase restarts after disable
        configure(2'd0, 16'd3, 16'd100, 1'b0);
        en = 1'b1;
        run(2);
        en = 1'b0;
        run(1);
        en = 1'b1;
        run(3);
        chk("R9 divider restarted", count, 0);
        run(1);
        chk("R9 R2 first step", count, 1);

        // R11: mode write while running has no effect
        configure(2'd0, 16'd0, 16'd5, 1'b0);
        en = 1'b1;
        run(2);
        mode_wr = 1'b1; mode_wdata = 2'd1;
        run(1);
        mode_wr = 1'b0;
        run(1);
        chk("R11 mode held while running", count, 4);

        // R3 scaled one-second case
        configure(2'd0, 16'd107, 16'd99, 1'b1);
        en = 1'b1;
        run(10799);
        chk("R3 scaled count before wrap", count, 99);
        chk("R3 scaled no event yet", ev_cnt, 0);
        chk("R7 scaled irq idle", irq, 0);
        run(1);
        chk("R3 scaled wrap", count, 0);
        chk("R6 scaled event", ev_cnt, 1);
        chk("R7 scaled irq", irq, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule